// File: doc/BRIEF.md
# Unique Monotonic Timestamp Read Unit

A shared free-running 64-bit time-of-day counter serves several processor read ports. The counter advances by one unit at a configurable bit position on every enable tick. Bit 0 is the least significant bit, and one count there is worth about 244 ps. A port can ask for a fast read or a unique read. A fast read returns the counter with every bit below the incrementing position forced to zero. A unique read returns the counter coarsened to a granule that leaves room for a per-port identifier, with that identifier placed in the freed low bits.

Unique reads must be strictly increasing on each port. Each port keeps its last unique result. A unique request is accepted only once the candidate value has moved past that stored value, and until then the request is stalled through the ready signal. A unique read therefore cannot repeat a value on its own port. It also cannot collide with a unique read on another port, because the identifiers differ.

The identifier format depends on the partition size. A partition with fewer processors than a limit uses a narrow logical port index. A larger partition uses a wider physical index. The wider index makes unique reads coarser and the stalls longer.

Top module: `tstamp_unit`

## Requirements
- R1: After synchronous reset the counter, all per-port last-unique values and all rspValid outputs are zero. The first unique read of the port whose identifier is 0 therefore waits until the counter reaches the identifier granule.
- R2: On each rising clock edge with tickEn high, the counter grows by 2^cfgResShift. With tickEn low it holds its value.
- R3: A request with reqUnique low (fast read) sees reqReady high in the same cycle. Its response data equals the counter value in the handshake cycle with bits [cfgResShift-1:0] cleared.
- R4: A unique response equals the counter value in the handshake cycle with bits [G-1:0] cleared, ORed with the port identifier, where G = max(cfgResShift, identifier width).
- R5: A unique request is accepted only when that candidate value is strictly greater than the port's last unique value. Otherwise reqReady stays low and the request waits. Fast reads leave the last unique value unchanged.
- R6: When partProcs is below LOGICAL_LIMIT (4), the identifier is the port index in a 2-bit field. Otherwise it is 8 plus the port index in a 4-bit field. A change of partProcs takes effect one cycle later.
- R7: Unique reads accepted on several ports in the same cycle all return distinct values.
- R8: rspValid of a port is high for exactly the one cycle after each handshake (reqValid and reqReady both high) and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Counter advance enable |
| cfgResShift | input | 6 | Bit position at which the counter increments |
| partProcs | input | 8 | Number of processors in the partition |
| reqValid | input | 4 | Per-port read request |
| reqUnique | input | 4 | Per-port read kind: 1 unique, 0 fast |
| reqReady | output | 4 | Per-port request accepted this cycle |
| rspValid | output | 4 | Per-port response strobe |
| rspData | output | 4x64 | Per-port read value, held until the next response |

## Verification
The hardest case to reach is a unique request that stalls with the counter frozen. The request must wait with its candidate exactly equal to the stored value, and it must be released on the first tick that moves the candidate past it. The stimulus gets there by accepting a unique read while tickEn is low and then asking again on the same port. Stalls are also provoked by switching the partition size between logical and physical identifiers while stored values sit above the new candidates. Finally, all ports request together under each resolution and mode, so that same-cycle grants can be compared against each other.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  // Per-port strobes from the control to the datapath
  typedef struct packed {
    logic takeFast;   // fast read accepted this cycle
    logic takeUniq;   // unique read accepted this cycle
  } portStrobe_t;

endpackage

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl #(
  parameter int NUM_PORTS     = 4,
  parameter int PROC_CNT_W    = 8,
  parameter int LOGICAL_LIMIT = 4
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic [PROC_CNT_W-1:0]                       partProcs,
  input  logic [NUM_PORTS-1:0]                        reqValid,
  input  logic [NUM_PORTS-1:0]                        reqUnique,
  input  logic [NUM_PORTS-1:0]                        uniqAhead,
  output logic [NUM_PORTS-1:0]                        reqReady,
  output tstamp_pkg::portStrobe_t [NUM_PORTS-1:0]     strobes,
  output logic                                        useLogical
);

  localparam logic [PROC_CNT_W-1:0] LIMIT_V = PROC_CNT_W'(LOGICAL_LIMIT);

  // Identifier format is registered, so a partition-size change applies next cycle
  always_ff @(posedge clk) begin
    if (rst) useLogical <= 1'b1;
    else     useLogical <= (partProcs < LIMIT_V);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_comb begin
      strobes[p].takeFast = reqValid[p] & ~reqUnique[p];
      strobes[p].takeUniq = reqValid[p] & reqUnique[p] & uniqAhead[p];
      reqReady[p]         = strobes[p].takeFast | strobes[p].takeUniq;
    end

    // R3
    fast_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (reqValid[p] && !reqUnique[p]) |-> reqReady[p]);
  end

endmodule

// File: rtl/tstamp_dp.sv
module tstamp_dp #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 64,
  parameter int LOG_ID_W  = 2,
  parameter int PHYS_ID_W = 4,
  parameter int PHYS_BASE = 8
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     tickEn,
  input  logic [$clog2(CNT_W)-1:0]                 cfgResShift,
  input  logic                                     useLogical,
  input  tstamp_pkg::portStrobe_t [NUM_PORTS-1:0]  strobes,
  output logic [NUM_PORTS-1:0]                     uniqAhead,
  output logic [NUM_PORTS-1:0]                     rspValid,
  output logic [NUM_PORTS-1:0][CNT_W-1:0]          rspData
);

  localparam int RES_W = $clog2(CNT_W);
  localparam logic [RES_W-1:0] LOG_W_V  = RES_W'(LOG_ID_W);
  localparam logic [RES_W-1:0] PHYS_W_V = RES_W'(PHYS_ID_W);

  logic [CNT_W-1:0]                 count;
  logic [CNT_W-1:0]                 incr;
  logic [CNT_W-1:0]                 fastMask;
  logic [CNT_W-1:0]                 uniqMask;
  logic [RES_W-1:0]                 idWidth;
  logic [RES_W-1:0]                 granBits;
  logic [NUM_PORTS-1:0][CNT_W-1:0]  logIds;
  logic [NUM_PORTS-1:0][CNT_W-1:0]  physIds;
  logic [NUM_PORTS-1:0][CNT_W-1:0]  candidate;
  logic [NUM_PORTS-1:0][CNT_W-1:0]  lastVal;
  logic [NUM_PORTS-1:0]             rspUniq;

  // Fixed identifiers, one per port, in both formats
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ids
    assign logIds[p]  = CNT_W'(p);
    assign physIds[p] = CNT_W'(PHYS_BASE + p);
  end

  // Resolution and granule masks
  always_comb begin
    incr     = CNT_W'(1) << cfgResShift;
    fastMask = {CNT_W{1'b1}} << cfgResShift;
    idWidth  = useLogical ? LOG_W_V : PHYS_W_V;
    granBits = (cfgResShift > idWidth) ? cfgResShift : idWidth;
    uniqMask = {CNT_W{1'b1}} << granBits;
  end

  // Unique candidates and the monotonic comparison per port
  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      candidate[p] = (count & uniqMask) | (useLogical ? logIds[p] : physIds[p]);
      uniqAhead[p] = candidate[p] > lastVal[p];
    end
  end

  // Free-running counter
  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (tickEn) count <= count + incr;
  end

  // Response and last-value registers
  always_ff @(posedge clk) begin
    if (rst) begin
      lastVal  <= '0;
      rspData  <= '0;
      rspValid <= '0;
      rspUniq  <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        rspValid[p] <= strobes[p].takeFast | strobes[p].takeUniq;
        rspUniq[p]  <= strobes[p].takeUniq;
        if (strobes[p].takeFast) rspData[p] <= count & fastMask;
        if (strobes[p].takeUniq) begin
          rspData[p] <= candidate[p];
          lastVal[p] <= candidate[p];
        end
      end
    end
  end

  // R2
  counter_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(count));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    // R5
    last_rise_chk: assert property (@(posedge clk) disable iff (rst)
      strobes[p].takeUniq |=> (lastVal[p] > $past(lastVal[p])));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(strobes[p].takeFast && strobes[p].takeUniq));

    for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
      // R7
      distinct_chk: assert property (@(posedge clk) disable iff (rst)
        (rspUniq[p] && rspUniq[q]) |-> (rspData[p] != rspData[q]));
    end
  end

endmodule

// File: rtl/tstamp_unit.sv
module tstamp_unit #(
  parameter int NUM_PORTS     = 4,
  parameter int CNT_W         = 64,
  parameter int LOG_ID_W      = 2,
  parameter int PHYS_ID_W     = 4,
  parameter int PHYS_BASE     = 8,
  parameter int PROC_CNT_W    = 8,
  parameter int LOGICAL_LIMIT = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             tickEn,
  input  logic [$clog2(CNT_W)-1:0]         cfgResShift,
  input  logic [PROC_CNT_W-1:0]            partProcs,
  input  logic [NUM_PORTS-1:0]             reqValid,
  input  logic [NUM_PORTS-1:0]             reqUnique,
  output logic [NUM_PORTS-1:0]             reqReady,
  output logic [NUM_PORTS-1:0]             rspValid,
  output logic [NUM_PORTS-1:0][CNT_W-1:0]  rspData
);

  tstamp_pkg::portStrobe_t [NUM_PORTS-1:0] strobes;
  logic [NUM_PORTS-1:0] uniqAhead;
  logic                 useLogical;

  tstamp_ctrl #(
    .NUM_PORTS(NUM_PORTS), .PROC_CNT_W(PROC_CNT_W), .LOGICAL_LIMIT(LOGICAL_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .partProcs(partProcs), .reqValid(reqValid),
    .reqUnique(reqUnique), .uniqAhead(uniqAhead), .reqReady(reqReady),
    .strobes(strobes), .useLogical(useLogical)
  );

  tstamp_dp #(
    .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .LOG_ID_W(LOG_ID_W),
    .PHYS_ID_W(PHYS_ID_W), .PHYS_BASE(PHYS_BASE)
  ) u_dp (
    .clk(clk), .rst(rst), .tickEn(tickEn), .cfgResShift(cfgResShift),
    .useLogical(useLogical), .strobes(strobes), .uniqAhead(uniqAhead),
    .rspValid(rspValid), .rspData(rspData)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hs
    // R8
    rsp_after_hs_chk: assert property (@(posedge clk) disable iff (rst)
      rspValid[p] |-> $past(reqValid[p] && reqReady[p]));
  end

endmodule

// File: tb/tb_tstamp_unit.sv
module tb_tstamp_unit;
  localparam int NP = 4;
  localparam int CW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic [5:0] cfgResShift = '0;
  logic [7:0] partProcs = 8'd2;
  logic [NP-1:0] reqValid = '0;
  logic [NP-1:0] reqUnique = '0;
  logic [NP-1:0] reqReady;
  logic [NP-1:0] rspValid;
  logic [NP-1:0][CW-1:0] rspData;

  always #4 clk = ~clk;   // 125 MHz

  tstamp_unit dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .cfgResShift(cfgResShift),
    .partProcs(partProcs), .reqValid(reqValid), .reqUnique(reqUnique),
    .reqReady(reqReady), .rspValid(rspValid), .rspData(rspData)
  );

  int checks = 0;
  int fails = 0;
  logic [CW-1:0] mCount = '0;
  logic [CW-1:0] mLast [NP];
  bit mLogical = 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] idOf(input int p);
    return mLogical ? CW'(p) : CW'(8 + p);
  endfunction

  function automatic logic [CW-1:0] candOf(input int p);
    int g;
    int w;
    w = mLogical ? 2 : 4;
    g = (int'(cfgResShift) > w) ? int'(cfgResShift) : w;
    return (mCount & ({CW{1'b1}} << g)) | idOf(p);
  endfunction

  // One clock: the model counter follows the tick seen at the edge
  task automatic advance();
    @(posedge clk);
    if (tickEn) mCount = mCount + (CW'(1) << cfgResShift);
    @(negedge clk);
  endtask

  task automatic setCfg(input int r, input int procs);
    cfgResShift = 6'(r);
    partProcs = 8'(procs);
    advance();
    advance();
    mLogical = (procs < 4);
  endtask

  task automatic fastRead(input int p);
    logic [CW-1:0] exp;
    reqValid[p] = 1'b1;
    reqUnique[p] = 1'b0;
    #1;
    check(reqReady[p] == 1'b1, "R3", "fast ready", CW'(reqReady[p]), 1);
    exp = mCount & ({CW{1'b1}} << cfgResShift);
    advance();
    reqValid[p] = 1'b0;
    #1;
    check(rspValid[p] == 1'b1, "R8", "fast rspValid", CW'(rspValid[p]), 1);
    check(rspData[p] == exp, "R3", "fast data (R2 count)", rspData[p], exp);
    advance();
    check(rspValid[p] == 1'b0, "R8", "rspValid one cycle", CW'(rspValid[p]), 0);
  endtask

  // Unique requests on the ports in 'who'; tick held off for holdOff cycles
  task automatic uniqBurst(input logic [NP-1:0] who, input int holdOff);
    logic [NP-1:0] pend;
    logic [NP-1:0] grant;
    logic [CW-1:0] expv [NP];
    pend = who;
    reqValid = reqValid | who;
    reqUnique = reqUnique | who;
    for (int c = 0; c < 400 && pend != '0; c++) begin
      tickEn = (c >= holdOff);
      #1;
      grant = '0;
      for (int p = 0; p < NP; p++) begin
        expv[p] = candOf(p);
        if (pend[p]) begin
          grant[p] = expv[p] > mLast[p];
          check(reqReady[p] == grant[p], "R5", "unique ready vs last",
                CW'(reqReady[p]), CW'(grant[p]));
        end
      end
      advance();
      for (int p = 0; p < NP; p++) begin
        if (grant[p]) begin
          reqValid[p] = 1'b0;
          reqUnique[p] = 1'b0;
          pend[p] = 1'b0;
          mLast[p] = expv[p];
        end
      end
      #1;
      for (int p = 0; p < NP; p++) begin
        if (who[p]) begin
          check(rspValid[p] == grant[p], "R8", "unique rspValid",
                CW'(rspValid[p]), CW'(grant[p]));
          if (grant[p])
            check(rspData[p] == expv[p], "R4", "unique data (R6 id)", rspData[p], expv[p]);
        end
      end
      for (int i = 0; i < NP; i++)
        for (int j = i + 1; j < NP; j++)
          if (grant[i] && grant[j])
            check(rspData[i] != rspData[j], "R7", "same-cycle distinct", rspData[i], rspData[j]);
    end
    if (pend != '0) check(1'b0, "R5", "unique never granted", CW'(pend), 0);
    tickEn = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rs [5];
    int ps [2];
    rs = '{0, 1, 2, 3, 6};
    ps = '{2, 9};
    for (int p = 0; p < NP; p++) mLast[p] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(rspValid == '0, "R1", "rspValid in reset", CW'(rspValid), 0);
    rst = 1'b0;
    advance();
    check(rspValid == '0, "R1", "rspValid after reset", CW'(rspValid), 0);
    fastRead(1);   // counter still zero

    // R1: port 0 identifier 0 stalls at count zero until the granule passes
    reqValid[0] = 1'b1;
    reqUnique[0] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(reqReady[0] == 1'b0, "R1", "id0 stall at zero", CW'(reqReady[0]), 0);
      advance();
    end
    uniqBurst(4'b0001, 0);

    // Sweep of resolutions and identifier formats
    foreach (rs[ri]) begin
      foreach (ps[pi]) begin
        tickEn = 1'b1;
        setCfg(rs[ri], ps[pi]);
        for (int p = 0; p < NP; p++) begin
          fastRead(p);
          uniqBurst(NP'(1) << p, 0);
          uniqBurst(NP'(1) << p, 0);
          uniqBurst(NP'(1) << p, 4);   // R5: frozen counter after a grant
          uniqBurst(NP'(1) << p, 4);
        end
        uniqBurst('1, 0);
        uniqBurst('1, 3);
        // R2: no tick, two fast reads see the same value
        tickEn = 1'b0;
        fastRead(0);
        fastRead(2);
        tickEn = 1'b1;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule